// File: doc/BRIEF.md
# Normalizing Shift-and-Count Unit

This unit left-justifies a 32-bit quantity formed by a 16-bit accumulator (upper half) and a 16-bit extension (lower half). It advances the pair one bit position per clock and stops at the first of two events: the shift budget runs out, or a 1 has reached the top bit of the accumulator. The budget is the low six bits of one of three 16-bit index registers, chosen by a 2-bit select field. When the unit finishes, it returns a rewritten word for the chosen index register that holds the unused budget, and it updates a carry flag that reports whether the stop was early.

The surrounding processor pulses `start` while it presents the select field, all three index registers and the accumulator and extension. The unit raises `busy` while it is shifting. It then pulses `done` for one cycle. In that cycle the shifted halves, the carry flag and the index write-back (enable, target and data) are valid. A zero budget, or a select value of 00, makes the operation a no-op. The no-op still gives a `done` pulse, but it performs no write and leaves the carry flag as it was.

Top module: `nsc_unit`

## Requirements
- R1: The halves shift left as one 32-bit value with the accumulator on top. The extension's bit 15 moves into the accumulator's bit 0, and a 0 enters the extension's bit 0.
- R2: Select codes 1, 2 and 3 take the budget from bits [5:0] of `idx_in[0]`, `idx_in[1]` and `idx_in[2]`. Code 0 selects no register.
- R3: At most one shift occurs per clock. Each shift takes one from the budget. Before each shift the unit tests for a zero budget and for a 1 in accumulator bit 15, and either one ends the run. A run with n shifts keeps `busy` high for n+1 cycles, and `done` follows in the next cycle.
- R4: In the `done` cycle `idx_wr_en` is high and `idx_wr_sel` equals the select code. The write data keeps bits [15:8] of the chosen register, has bits [7:6] at 0 and carries the unused budget in [5:0]. `idx_wr_en` is never high outside `done`.
- R5: If the budget is zero or the select code is 0, no shift occurs and `busy` stays low. `done` pulses in the cycle after `start`, `idx_wr_en` stays low and `carry` keeps its prior value.
- R6: If accumulator bit 15 is 1 at the start and the budget is nonzero, no shift occurs. `carry` becomes 1 and the write data holds the unchanged budget with bits [7:6] at 0.
- R7: `carry` becomes 1 only when a run ends on the top-bit condition with a nonzero unused budget. It becomes 0 when the budget is used up, even if the last shift put a 1 into accumulator bit 15. It changes only on entry to the `done` cycle.
- R8: `done` lasts exactly one cycle and is never high together with `busy`. A `start` pulse while `busy` or `done` is high is ignored.
- R9: A synchronous active-high `rst` leaves `busy`, `done`, `idx_wr_en` and `carry` at 0.
- R10: A budget of 63 on an all-zero value gives 63 shifts, an unused budget of 0 and `carry` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (sampled when idle) |
| sel_in | input | 2 | Index-register select code |
| idx_in | input | 3x16 | The three index registers, element 0 = code 1 |
| acc_in | input | 16 | Accumulator value to shift |
| ext_in | input | 16 | Extension value to shift |
| busy | output | 1 | Shifting in progress |
| done | output | 1 | One-cycle result-valid pulse |
| acc_out | output | 16 | Shifted accumulator |
| ext_out | output | 16 | Shifted extension |
| carry | output | 1 | Carry flag |
| idx_wr_en | output | 1 | Index register write enable |
| idx_wr_sel | output | 2 | Select code of the register to write |
| idx_wr_data | output | 16 | Rewritten index register word |

## Verification
The two stop conditions can occur together. When the final unit of budget is spent on the same shift that moves a 1 into accumulator bit 15, the budget test wins and `carry` must be 0. The bench provokes this with budget 4 against an accumulator whose leading 1 sits four places below the top. It also runs budgets of 3, 5 and 6 against the same value, so that the coincident case is compared with a pure budget-exhaust stop and with early stops that have one or two units left over. For each case the scoreboard checks the shifted halves, the unused budget in the write data, the carry value and the number of `busy` cycles.

// File: rtl/nsc_pkg.sv
package nsc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } nsc_state_t;
endpackage

// File: rtl/nsc_src_sel.sv
module nsc_src_sel #(
    parameter int NUM_IDX = 3,
    parameter int IDX_W   = 16,
    localparam int SEL_W  = $clog2(NUM_IDX + 1)
) (
    input  logic [SEL_W-1:0]              sel,
    input  logic [NUM_IDX-1:0][IDX_W-1:0] idx_in,
    output logic [IDX_W-1:0]              word,
    output logic                          valid
);
    logic [NUM_IDX-1:0] hit;

    for (genvar i = 0; i < NUM_IDX; i++) begin : g_hit
        assign hit[i] = (sel == SEL_W'(i + 1));
    end

    always_comb begin
        word = '0;
        for (int i = 0; i < NUM_IDX; i++) begin
            word = word | (idx_in[i] & {IDX_W{hit[i]}});
        end
    end

    assign valid = |hit;

    always_comb begin
        assert ($onehot0(hit)) else $error("assert_select_onehot_R2");
    end
endmodule

// File: rtl/nsc_shifter.sv
module nsc_shifter #(
    parameter int ACC_W = 16
) (
    input  logic [ACC_W-1:0] acc,
    input  logic [ACC_W-1:0] ext,
    output logic [ACC_W-1:0] acc_nx,
    output logic [ACC_W-1:0] ext_nx,
    output logic             top_one
);
    localparam int PAIR_W = 2 * ACC_W;

    logic [PAIR_W-1:0] pair;
    logic [PAIR_W-1:0] pair_sh;

    assign pair    = {acc, ext};
    assign pair_sh = {pair[PAIR_W-2:0], 1'b0};
    assign acc_nx  = pair_sh[PAIR_W-1:ACC_W];
    assign ext_nx  = pair_sh[ACC_W-1:0];
    assign top_one = acc[ACC_W-1];
endmodule

// File: rtl/nsc_ctrl.sv
module nsc_ctrl
    import nsc_pkg::*;
#(
    parameter int ACC_W   = 16,
    parameter int IDX_W   = 16,
    parameter int CNT_W   = 6,
    parameter int CLR_W   = 2,
    parameter int SEL_W   = 2,
    localparam int KEEP_W = IDX_W - CNT_W - CLR_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [SEL_W-1:0] sel_in,
    input  logic [IDX_W-1:0] src_word,
    input  logic             src_valid,
    input  logic [ACC_W-1:0] acc_in,
    input  logic [ACC_W-1:0] ext_in,
    input  logic [ACC_W-1:0] acc_nx,
    input  logic [ACC_W-1:0] ext_nx,
    input  logic             top_one,
    output logic [ACC_W-1:0] acc_q,
    output logic [ACC_W-1:0] ext_q,
    output logic             busy,
    output logic             done,
    output logic             carry,
    output logic             idx_wr_en,
    output logic [SEL_W-1:0] idx_wr_sel,
    output logic [IDX_W-1:0] idx_wr_data
);
    typedef struct packed {
        nsc_state_t       st;
        logic [ACC_W-1:0] acc;
        logic [ACC_W-1:0] ext;
        logic [CNT_W-1:0] cnt;
        logic [IDX_W-1:0] word;
        logic [SEL_W-1:0] sel;
        logic             wr;
        logic             carry;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.acc  = acc_in;
                    r_d.ext  = ext_in;
                    r_d.sel  = sel_in;
                    r_d.word = src_word;
                    r_d.cnt  = src_word[CNT_W-1:0];
                    if (!src_valid || (src_word[CNT_W-1:0] == '0)) begin
                        r_d.wr = 1'b0;
                        r_d.st = ST_DONE;
                    end else begin
                        r_d.wr = 1'b1;
                        r_d.st = ST_RUN;
                    end
                end
            end
            ST_RUN: begin
                if (r_q.cnt == '0) begin
                    r_d.carry = 1'b0;
                    r_d.st    = ST_DONE;
                end else if (top_one) begin
                    r_d.carry = 1'b1;
                    r_d.st    = ST_DONE;
                end else begin
                    r_d.acc = acc_nx;
                    r_d.ext = ext_nx;
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            ST_DONE: begin
                r_d.st = ST_IDLE;
            end
            default: begin
                r_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q       <= '0;
            r_q.st    <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign acc_q       = r_q.acc;
    assign ext_q       = r_q.ext;
    assign busy        = (r_q.st == ST_RUN);
    assign done        = (r_q.st == ST_DONE);
    assign carry       = r_q.carry;
    assign idx_wr_en   = done && r_q.wr;
    assign idx_wr_sel  = r_q.sel;
    assign idx_wr_data = {r_q.word[IDX_W-1:IDX_W-KEEP_W], {CLR_W{1'b0}}, r_q.cnt};

    assert_done_not_busy_R8: assert property (@(posedge clk) disable iff (rst)
        !(busy && done));

    assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_busy_then_done_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    assert_one_shift_per_cycle_R3: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> ((r_q.cnt + 1'b1) == $past(r_q.cnt)));

    assert_write_only_done_R4: assert property (@(posedge clk) disable iff (rst)
        idx_wr_en |-> done);

    assert_flags_cleared_R4: assert property (@(posedge clk) disable iff (rst)
        idx_wr_en |-> (idx_wr_data[CNT_W+CLR_W-1:CNT_W] == '0));

    assert_carry_only_at_done_R7: assert property (@(posedge clk) disable iff (rst)
        !$stable(carry) |-> done);

    assert_carry_means_residual_R7: assert property (@(posedge clk) disable iff (rst)
        (done && idx_wr_en && carry) |-> (idx_wr_data[CNT_W-1:0] != '0));

    assert_noop_keeps_carry_R5: assert property (@(posedge clk) disable iff (rst)
        (done && !idx_wr_en) |-> $stable(carry));
endmodule

// File: rtl/nsc_unit.sv
module nsc_unit #(
    parameter int ACC_W   = 16,
    parameter int IDX_W   = 16,
    parameter int CNT_W   = 6,
    parameter int CLR_W   = 2,
    parameter int NUM_IDX = 3,
    localparam int SEL_W  = $clog2(NUM_IDX + 1)
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          start,
    input  logic [SEL_W-1:0]              sel_in,
    input  logic [NUM_IDX-1:0][IDX_W-1:0] idx_in,
    input  logic [ACC_W-1:0]              acc_in,
    input  logic [ACC_W-1:0]              ext_in,
    output logic                          busy,
    output logic                          done,
    output logic [ACC_W-1:0]              acc_out,
    output logic [ACC_W-1:0]              ext_out,
    output logic                          carry,
    output logic                          idx_wr_en,
    output logic [SEL_W-1:0]              idx_wr_sel,
    output logic [IDX_W-1:0]              idx_wr_data
);
    logic [IDX_W-1:0] src_word;
    logic             src_valid;
    logic [ACC_W-1:0] acc_nx;
    logic [ACC_W-1:0] ext_nx;
    logic             top_one;

    nsc_src_sel #(
        .NUM_IDX (NUM_IDX),
        .IDX_W   (IDX_W)
    ) u_src (
        .sel    (sel_in),
        .idx_in (idx_in),
        .word   (src_word),
        .valid  (src_valid)
    );

    nsc_shifter #(
        .ACC_W (ACC_W)
    ) u_shift (
        .acc     (acc_out),
        .ext     (ext_out),
        .acc_nx  (acc_nx),
        .ext_nx  (ext_nx),
        .top_one (top_one)
    );

    nsc_ctrl #(
        .ACC_W (ACC_W),
        .IDX_W (IDX_W),
        .CNT_W (CNT_W),
        .CLR_W (CLR_W),
        .SEL_W (SEL_W)
    ) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .sel_in      (sel_in),
        .src_word    (src_word),
        .src_valid   (src_valid),
        .acc_in      (acc_in),
        .ext_in      (ext_in),
        .acc_nx      (acc_nx),
        .ext_nx      (ext_nx),
        .top_one     (top_one),
        .acc_q       (acc_out),
        .ext_q       (ext_out),
        .busy        (busy),
        .done        (done),
        .carry       (carry),
        .idx_wr_en   (idx_wr_en),
        .idx_wr_sel  (idx_wr_sel),
        .idx_wr_data (idx_wr_data)
    );
endmodule

// File: tb/nsc_unit_tb_top.sv
module nsc_unit_tb_top;
    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start = 1'b0;
    logic [1:0]       sel_in = 2'd0;
    logic [2:0][15:0] idx_in = '0;
    logic [15:0]      acc_in = '0;
    logic [15:0]      ext_in = '0;
    logic             busy, done, carry, idx_wr_en;
    logic [15:0]      acc_out, ext_out, idx_wr_data;
    logic [1:0]       idx_wr_sel;

    always #2 clk = ~clk;

    nsc_unit dut_i (
        .clk(clk), .rst(rst), .start(start), .sel_in(sel_in), .idx_in(idx_in),
        .acc_in(acc_in), .ext_in(ext_in), .busy(busy), .done(done),
        .acc_out(acc_out), .ext_out(ext_out), .carry(carry),
        .idx_wr_en(idx_wr_en), .idx_wr_sel(idx_wr_sel), .idx_wr_data(idx_wr_data)
    );

    typedef struct {
        logic [15:0] acc;
        logic [15:0] ext;
        logic        wr;
        logic [1:0]  wsel;
        logic [15:0] wdata;
        logic        carry;
        int          busy_cyc;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   failures = 0;
    logic model_carry = 1'b0;
    int   busy_cnt = 0;
    bit   finished = 0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    // Model of the requirements: budget from bits [5:0] of the selected word
    function automatic exp_t model(input logic [1:0] s, input logic [2:0][15:0] ix,
                                   input logic [15:0] a, input logic [15:0] e, input string tag);
        exp_t        x;
        logic [31:0] v;
        logic [15:0] w;
        int          c;
        int          n;
        v = {a, e};
        w = (s == 2'd0) ? 16'h0 : ix[s - 1];
        c = int'(w[5:0]);
        n = 0;
        x.tag = tag;
        x.wsel = s;
        if (s == 2'd0 || c == 0) begin
            x.wr = 1'b0;
            x.carry = model_carry;
            x.busy_cyc = 0;
        end else begin
            while (c != 0 && !v[31]) begin
                v = v << 1;
                c--;
                n++;
            end
            x.wr = 1'b1;
            x.carry = (c != 0);
            x.busy_cyc = n + 1;
            model_carry = x.carry;
        end
        x.acc = v[31:16];
        x.ext = v[15:0];
        x.wdata = {w[15:8], 2'b00, 6'(c)};
        return x;
    endfunction

    task automatic run_op(input string tag, input logic [1:0] s, input logic [2:0][15:0] ix,
                          input logic [15:0] a, input logic [15:0] e, input int extra_start_at);
        exp_q.push_back(model(s, ix, a, e, tag));
        @(negedge clk);
        sel_in = s; idx_in = ix; acc_in = a; ext_in = e; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // disturb inputs so a late sample would be visible
        acc_in = ~a; ext_in = ~e; idx_in = ~ix;
        for (int k = 0; k < 200 && !done; k++) begin
            if (extra_start_at == k) start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        @(negedge clk);
    endtask

    // Monitor: compares each result against the scoreboard at done
    always @(negedge clk) begin
        if (!rst) begin
            if (done) begin
                if (exp_q.size() == 0) begin
                    check("R8 unexpected done", 32'd1, 32'd0);
                end else begin
                    exp_t x;
                    x = exp_q.pop_front();
                    check({"R1 acc ", x.tag}, 32'(acc_out), 32'(x.acc));
                    check({"R1 ext ", x.tag}, 32'(ext_out), 32'(x.ext));
                    check({"R4 wr_en ", x.tag}, 32'(idx_wr_en), 32'(x.wr));
                    if (x.wr) begin
                        check({"R4 wr_sel ", x.tag}, 32'(idx_wr_sel), 32'(x.wsel));
                        check({"R4 wr_data ", x.tag}, 32'(idx_wr_data), 32'(x.wdata));
                    end
                    check({"R7 carry ", x.tag}, 32'(carry), 32'(x.carry));
                    check({"R3 busy cycles ", x.tag}, 32'(busy_cnt), 32'(x.busy_cyc));
                end
                busy_cnt = 0;
            end else if (busy) begin
                busy_cnt++;
            end
            if (busy && done) check("R8 busy with done", 32'd1, 32'd0);
        end
    end

    task automatic finish_up();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        logic [2:0][15:0] ix;
        logic [15:0] la, le;
        repeat (3) @(negedge clk);
        // R9 reset state
        check("R9 busy", 32'(busy), 32'd0);
        check("R9 done", 32'(done), 32'd0);
        check("R9 wr_en", 32'(idx_wr_en), 32'd0);
        check("R9 carry", 32'(carry), 32'd0);
        rst = 1'b0;

        // R7 worked cases: leading 1 four places below the top
        ix = {16'h4D07, 16'h3CC0, 16'hA5C3};
        run_op("R7 budget3 exhaust", 2'd1, ix, 16'h0ABC, 16'h1234, -1);
        ix = {16'h4D07, 16'h3CC4, 16'hA5C3};
        run_op("R7 budget4 coincident", 2'd2, ix, 16'h0ABC, 16'h1234, -1);
        ix = {16'hFFC5, 16'h3CC4, 16'hA5C3};
        run_op("R7 budget5 early", 2'd3, ix, 16'h0ABC, 16'h1234, -1);
        ix = {16'hFFC5, 16'h3CC4, 16'h12C6};
        run_op("R7 budget6 early", 2'd1, ix, 16'h0ABC, 16'h1234, -1);

        // R5 zero budget keeps carry at 1, then at 0
        ix = {16'hFFC5, 16'h77C0, 16'h12C6};
        run_op("R5 zero budget carry1", 2'd2, ix, 16'h0001, 16'h0000, -1);
        ix = {16'h0001, 16'h0001, 16'h0001};
        run_op("R10 sets carry0", 2'd3, ix, 16'h0000, 16'h0000, -1);
        ix = {16'hFFC0, 16'h0005, 16'h0007};
        run_op("R5 zero budget carry0", 2'd3, ix, 16'h8000, 16'h0000, -1);
        // R5 select 0 is a no-op
        ix = {16'h0009, 16'h0009, 16'h0009};
        run_op("R5 select0", 2'd0, ix, 16'h0001, 16'h0000, -1);

        // R6 top bit already set
        ix = {16'hBEC9, 16'h0001, 16'h0001};
        run_op("R6 top set", 2'd3, ix, 16'h8001, 16'h5555, -1);

        // R1 crossing from extension into accumulator
        ix = {16'h0000, 16'h0000, 16'h0011};
        run_op("R1 cross", 2'd1, ix, 16'h0000, 16'h8000, -1);
        ix = {16'h0000, 16'h003F, 16'h0000};
        run_op("R1 from ext bit0", 2'd2, ix, 16'h0000, 16'h0001, -1);

        // R10 maximum budget on zero value
        ix = {16'h00FF, 16'h0000, 16'h0000};
        run_op("R10 max budget", 2'd3, ix, 16'h0000, 16'h0000, -1);

        // R8 start while busy is ignored
        ix = {16'h0000, 16'h0000, 16'h0014};
        run_op("R8 start during busy", 2'd1, ix, 16'h0000, 16'h0003, 3);

        // R2 assorted patterns
        la = 16'h0135; le = 16'hC0DE;
        for (int i = 0; i < 8; i++) begin
            ix[0] = 16'h1100 ^ 16'(i * 16'h0947);
            ix[1] = 16'h2200 ^ 16'(i * 16'h1363);
            ix[2] = 16'h3300 ^ 16'(i * 16'h0B2D);
            run_op("R2 pattern", 2'((i % 3) + 1), ix, la, le, -1);
            la = {la[14:0], la[15] ^ la[13]} >> (i % 4);
            le = le * 16'd5 + 16'd3;
        end

        repeat (4) @(negedge clk);
        check("R8 scoreboard empty", 32'(exp_q.size()), 32'd0);
        finish_up();
    end
endmodule